// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block is the control unit of a small accumulator machine. It walks a control store of 32-bit microinstructions with an 8-bit control address register. A control buffer register presents the microinstruction at that address to the datapath as a control word. Every instruction runs a shared three-step fetch. The fetch ends by adding the opcode from the instruction register to the control address. This lands on one entry of a jump table, and each entry branches to the routine for that opcode. Each routine returns to the fetch by clearing the control address. The conditional jump routine tests the accumulator sign bit to choose between loading the program counter and incrementing it.

The control store contents are computed from named fields inside the block. The datapath that acts on the control word is outside this block.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, `ctrl_word` is 0. The first word after release is fetch step 0: memory read (bit 16) plus CAR increment (bit 23).
- R2: The fetch runs as three words in order. They are read|increment, then load IR (bit 21)|increment, then opcode add (bit 25) alone.
- R3: The opcode-add step moves CAR to 2+opcode. Opcodes 1..C reach entries that set branch-load (bit 24) with branch field bits 7..0. The targets are 14h, 19h, 1Eh, 23h, 41h, 28h, 2Dh, 32h, 37h, 3Ch, 46h and 4Bh, in opcode order.
- R4: The next CAR is chosen in a fixed priority order. First comes CAR reset to 0 (bit 26), then branch load, then conditional branch (bit 27), then opcode add, then increment. With none of these bits set, CAR holds.
- R5: LOAD, ADD, SUB, AND, OR and MPY share a four-word pattern.
  - Word 1 is MAR from MBR (bit 18) plus increment.
  - Word 2 is PC increment (bit 9) plus read plus increment. For LOAD it also clears ACC (bit 11).
  - Word 3 is BR from MBR (bit 22) plus the ALU code in bits 15..12 plus increment. The ALU codes are 3 for LOAD and ADD, 4 for SUB, 6 for AND, 7 for OR and Bh for MPY.
  - Word 4 is CAR reset alone.
- R6: STORE issues three words. They are MAR from MBR plus increment, then ACC to MBR (bit 20) plus PC increment plus write (bit 17) plus increment, then CAR reset.
- R7: NOT, SHIFTR and SHIFTL issue three words. They are MAR from MBR plus increment, then PC increment plus ALU code (8, 9 or Ah) plus increment, then CAR reset.
- R8: The jump routine issues MAR from MBR plus increment, then a conditional branch to 44h.
  - With `acc_sign` 0, the next word is PC load from MBR (bit 10) plus CAR reset.
  - With `acc_sign` 1, the next word is PC increment plus CAR reset.
- R9: The HALT entry branches to 4Bh, and the word at 4Bh branches to itself. The control word then stays constant until reset.
- R10: Every control-store address with no assigned word holds CAR reset alone. Opcode Dh therefore returns straight to the fetch.
- R11: Bits 31..28 of every control word are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 8 | Opcode held in the instruction register |
| acc_sign | input | 1 | Sign bit of the accumulator |
| ctrl_word | output | 32 | Current microinstruction from the control buffer register |

## Verification
The assertions check the sequencing rules on every cycle. They check that each next-address bit moves CAR as its priority demands, and that the conditional branch follows `acc_sign`. They also check that the HALT word never changes and that the reserved bits stay zero.

Only the scoreboard scenarios can show the control-store contents. These are the exact word sequence of every opcode routine, the dispatch targets, the return to fetch after each routine, the filler behaviour for an undefined opcode, and the exit from HALT through reset.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int CAR_W  = 8;
    localparam int WORD_W = 32;
    localparam int OP_W   = 8;

    // Control word field positions (decoded by the datapath)
    localparam int B_PC_INC  = 9;
    localparam int B_PC_LD   = 10;
    localparam int B_ACC_CLR = 11;
    localparam int B_ALU_LO  = 12;
    localparam int B_MEM_RD  = 16;
    localparam int B_MEM_WR  = 17;
    localparam int B_MAR_MBR = 18;
    localparam int B_MBR_ACC = 20;
    localparam int B_IR_LD   = 21;
    localparam int B_BR_LD   = 22;
    localparam int B_SEQ_INC = 23;
    localparam int B_SEQ_JMP = 24;
    localparam int B_SEQ_OP  = 25;
    localparam int B_SEQ_RST = 26;
    localparam int B_SEQ_CND = 27;
    localparam int SEQ_BITS  = B_SEQ_CND - B_SEQ_INC + 1;

    typedef enum logic [3:0] {
        ALU_NOP = 4'h0,
        ALU_ADD = 4'h3,
        ALU_SUB = 4'h4,
        ALU_AND = 4'h6,
        ALU_OR  = 4'h7,
        ALU_NOT = 4'h8,
        ALU_SHR = 4'h9,
        ALU_SHL = 4'hA,
        ALU_MUL = 4'hB
    } alu_op_e;

    typedef enum logic [2:0] {
        NX_HOLD,
        NX_INC,
        NX_OPADD,
        NX_BRANCH,
        NX_ZERO
    } nxt_sel_e;

    // Fixed control-store layout
    localparam int DISP_BASE  = 2;
    localparam int NUM_OPS    = 12;
    localparam int R_STORE    = 'h14;
    localparam int R_LOAD     = 'h19;
    localparam int R_ADD      = 'h1E;
    localparam int R_SUB      = 'h23;
    localparam int R_AND      = 'h28;
    localparam int R_OR       = 'h2D;
    localparam int R_NOT      = 'h32;
    localparam int R_SHR      = 'h37;
    localparam int R_SHL      = 'h3C;
    localparam int R_JMP      = 'h41;
    localparam int R_MUL      = 'h46;
    localparam int R_HALT     = 'h4B;
    localparam int JMP_TAKEN  = R_JMP + 2;
    localparam int JMP_NEG    = R_JMP + 3;

    function automatic logic [WORD_W-1:0] fbit(input int pos);
        return WORD_W'(1) << pos;
    endfunction

    function automatic logic [WORD_W-1:0] falu(input alu_op_e op);
        return WORD_W'(op) << B_ALU_LO;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter int ADDR_W = CAR_W,
    parameter int DW     = WORD_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DW-1:0]     word
);

    localparam logic [DW-1:0] W_INC  = DW'(fbit(B_SEQ_INC));
    localparam logic [DW-1:0] W_BACK = DW'(fbit(B_SEQ_RST));
    localparam logic [DW-1:0] W_MAR  = DW'(fbit(B_MAR_MBR) | fbit(B_SEQ_INC));
    localparam logic [DW-1:0] W_RDPC = DW'(fbit(B_PC_INC) | fbit(B_MEM_RD) | fbit(B_SEQ_INC));
    localparam logic [DW-1:0] W_BRA  = DW'(fbit(B_SEQ_JMP));

    function automatic int entry_target(input int op);
        case (op)
            1:       return R_STORE;
            2:       return R_LOAD;
            3:       return R_ADD;
            4:       return R_SUB;
            5:       return R_JMP;
            6:       return R_AND;
            7:       return R_OR;
            8:       return R_NOT;
            9:       return R_SHR;
            10:      return R_SHL;
            11:      return R_MUL;
            default: return R_HALT;
        endcase
    endfunction

    function automatic logic [DW-1:0] alu_step(input alu_op_e op);
        return DW'(fbit(B_BR_LD) | falu(op)) | W_INC;
    endfunction

    function automatic logic [DW-1:0] branch_to(input int tgt);
        return W_BRA | DW'(tgt[7:0]);
    endfunction

    int a;

    always_comb begin
        a    = int'(addr);
        word = W_BACK;
        if (a > DISP_BASE && a <= DISP_BASE + NUM_OPS) begin
            word = branch_to(entry_target(a - DISP_BASE));
        end
        case (a)
            0: word = DW'(fbit(B_MEM_RD)) | W_INC;
            1: word = DW'(fbit(B_IR_LD)) | W_INC;
            2: word = DW'(fbit(B_SEQ_OP));
            // STORE
            R_STORE:     word = W_MAR;
            R_STORE + 1: word = DW'(fbit(B_MBR_ACC) | fbit(B_PC_INC) | fbit(B_MEM_WR)) | W_INC;
            // LOAD
            R_LOAD:      word = W_MAR;
            R_LOAD + 1:  word = W_RDPC | DW'(fbit(B_ACC_CLR));
            R_LOAD + 2:  word = alu_step(ALU_ADD);
            // two-operand arithmetic and logic
            R_ADD:       word = W_MAR;
            R_ADD + 1:   word = W_RDPC;
            R_ADD + 2:   word = alu_step(ALU_ADD);
            R_SUB:       word = W_MAR;
            R_SUB + 1:   word = W_RDPC;
            R_SUB + 2:   word = alu_step(ALU_SUB);
            R_AND:       word = W_MAR;
            R_AND + 1:   word = W_RDPC;
            R_AND + 2:   word = alu_step(ALU_AND);
            R_OR:        word = W_MAR;
            R_OR + 1:    word = W_RDPC;
            R_OR + 2:    word = alu_step(ALU_OR);
            R_MUL:       word = W_MAR;
            R_MUL + 1:   word = W_RDPC;
            R_MUL + 2:   word = alu_step(ALU_MUL);
            // single-operand accumulator operations
            R_NOT:       word = W_MAR;
            R_NOT + 1:   word = DW'(fbit(B_PC_INC) | falu(ALU_NOT)) | W_INC;
            R_SHR:       word = W_MAR;
            R_SHR + 1:   word = DW'(fbit(B_PC_INC) | falu(ALU_SHR)) | W_INC;
            R_SHL:       word = W_MAR;
            R_SHL + 1:   word = DW'(fbit(B_PC_INC) | falu(ALU_SHL)) | W_INC;
            // conditional jump on accumulator sign
            R_JMP:       word = W_MAR;
            R_JMP + 1:   word = DW'(fbit(B_SEQ_CND)) | DW'(JMP_NEG);
            JMP_TAKEN:   word = DW'(fbit(B_PC_LD)) | W_BACK;
            JMP_NEG:     word = DW'(fbit(B_PC_INC)) | W_BACK;
            // halt: spin on itself
            R_HALT:      word = branch_to(R_HALT);
            default:     ;
        endcase
    end

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int AW = CAR_W,
    parameter int OW = OP_W
) (
    input  logic [SEQ_BITS-1:0] seq_ctl,
    input  logic [AW-1:0]       br_field,
    input  logic [AW-1:0]       car,
    input  logic [OW-1:0]       opcode,
    input  logic                acc_sign,
    output logic [AW-1:0]       car_nxt
);

    localparam int I_INC = B_SEQ_INC - B_SEQ_INC;
    localparam int I_JMP = B_SEQ_JMP - B_SEQ_INC;
    localparam int I_OP  = B_SEQ_OP  - B_SEQ_INC;
    localparam int I_RST = B_SEQ_RST - B_SEQ_INC;
    localparam int I_CND = B_SEQ_CND - B_SEQ_INC;

    nxt_sel_e sel;

    always_comb begin
        if (seq_ctl[I_RST])      sel = NX_ZERO;
        else if (seq_ctl[I_JMP]) sel = NX_BRANCH;
        else if (seq_ctl[I_CND]) sel = acc_sign ? NX_BRANCH : NX_INC;
        else if (seq_ctl[I_OP])  sel = NX_OPADD;
        else if (seq_ctl[I_INC]) sel = NX_INC;
        else                     sel = NX_HOLD;
    end

    always_comb begin
        case (sel)
            NX_ZERO:   car_nxt = '0;
            NX_BRANCH: car_nxt = br_field;
            NX_OPADD:  car_nxt = AW'(car + AW'(opcode));
            NX_INC:    car_nxt = AW'(car + AW'(1));
            default:   car_nxt = car;
        endcase
    end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int AW = CAR_W,
    parameter int DW = WORD_W,
    parameter int OW = OP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [OW-1:0] opcode,
    input  logic          acc_sign,
    output logic [DW-1:0] ctrl_word
);

    typedef struct packed {
        logic [AW-1:0] car;
        logic [DW-1:0] cbr;
    } seq_state_t;

    seq_state_t    st_d, st_q;
    logic [AW-1:0] car_nxt;
    logic [DW-1:0] store_word;

    useq_next #(.AW(AW), .OW(OW)) u_next (
        .seq_ctl  (st_q.cbr[B_SEQ_CND:B_SEQ_INC]),
        .br_field (st_q.cbr[AW-1:0]),
        .car      (st_q.car),
        .opcode   (opcode),
        .acc_sign (acc_sign),
        .car_nxt  (car_nxt)
    );

    useq_store #(.ADDR_W(AW), .DW(DW)) u_store (
        .addr (car_nxt),
        .word (store_word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.car = car_nxt;
        st_d.cbr = store_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_word = st_q.cbr;

endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
    import useq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  opcode,
    input logic        acc_sign,
    input logic [31:0] ctrl_word,
    input logic [7:0]  car
);

    logic c_inc, c_jmp, c_op, c_rst, c_cnd;
    assign c_inc = ctrl_word[B_SEQ_INC];
    assign c_jmp = ctrl_word[B_SEQ_JMP];
    assign c_op  = ctrl_word[B_SEQ_OP];
    assign c_rst = ctrl_word[B_SEQ_RST];
    assign c_cnd = ctrl_word[B_SEQ_CND];

    AST_SEQ_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        c_rst |=> car == 8'h00); // R4

    AST_SEQ_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (c_jmp && !c_rst) |=> car == $past(ctrl_word[7:0])); // R4

    AST_COND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cnd && !c_jmp && !c_rst && acc_sign) |=> car == $past(ctrl_word[7:0])); // R8

    AST_COND_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cnd && !c_jmp && !c_rst && !acc_sign) |=> car == 8'($past(car) + 8'd1)); // R8

    AST_OPADD: assert property (@(posedge clk) disable iff (!rst_n)
        (c_op && !c_cnd && !c_jmp && !c_rst) |=> car == 8'($past(car) + $past(opcode))); // R3

    AST_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (c_inc && !c_op && !c_cnd && !c_jmp && !c_rst) |=> car == 8'($past(car) + 8'd1)); // R4

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_inc && !c_op && !c_cnd && !c_jmp && !c_rst) |=> $stable(car)); // R4

    AST_HALT_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
        (c_jmp && ctrl_word[7:0] == 8'(R_HALT) && car == 8'(R_HALT)) |=> $stable(ctrl_word)); // R9

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[31:28] == 4'h0); // R11

endmodule

bind useq_ctrl useq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (opcode),
    .acc_sign  (acc_sign),
    .ctrl_word (ctrl_word),
    .car       (st_q.car)
);

// File: tb/sim_useq_ctrl.sv
module sim_useq_ctrl;

    localparam int PERIOD = 10;

    localparam logic [31:0] PCINC = 32'h1 << 9;
    localparam logic [31:0] PCLD  = 32'h1 << 10;
    localparam logic [31:0] ACCZ  = 32'h1 << 11;
    localparam logic [31:0] RD    = 32'h1 << 16;
    localparam logic [31:0] WR    = 32'h1 << 17;
    localparam logic [31:0] MARM  = 32'h1 << 18;
    localparam logic [31:0] MBRA  = 32'h1 << 20;
    localparam logic [31:0] IRL   = 32'h1 << 21;
    localparam logic [31:0] BRL   = 32'h1 << 22;
    localparam logic [31:0] INC   = 32'h1 << 23;
    localparam logic [31:0] JMP   = 32'h1 << 24;
    localparam logic [31:0] OPA   = 32'h1 << 25;
    localparam logic [31:0] BACK  = 32'h1 << 26;
    localparam logic [31:0] COND  = 32'h1 << 27;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  opcode;
    logic        acc_sign;
    logic [31:0] ctrl_word;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    useq_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode    (opcode),
        .acc_sign  (acc_sign),
        .ctrl_word (ctrl_word)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [31:0] alu(input int code);
        return 32'(code) << 12;
    endfunction

    task automatic push(input logic [31:0] w, input string tag);
        exp_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
    endtask

    task automatic fetch(input logic [7:0] op, input int tgt);
        opcode = op;
        push(RD | INC, "R1/R2 fetch0");
        push(IRL | INC, "R2 fetch1");
        push(OPA, "R2 fetch2");
        push(JMP | 32'(tgt), "R3 dispatch");
    endtask

    task automatic two_op(input logic [7:0] op, input int tgt, input int code, input logic clr, input string tag);
        fetch(op, tgt);
        push(MARM | INC, tag);
        push(PCINC | RD | INC | (clr ? ACCZ : 32'h0), tag);
        push(BRL | alu(code) | INC, tag);
        push(BACK, tag);
        drain();
    endtask

    task automatic one_op(input logic [7:0] op, input int tgt, input int code);
        fetch(op, tgt);
        push(MARM | INC, "R7");
        push(PCINC | alu(code) | INC, "R7");
        push(BACK, "R7");
        drain();
    endtask

    task automatic jump(input logic sgn);
        acc_sign = sgn;
        fetch(8'h05, 'h41);
        push(MARM | INC, "R8");
        push(COND | 32'h44, "R8");
        push(sgn ? (PCINC | BACK) : (PCLD | BACK), "R8");
        drain();
    endtask

    // Monitor: compare away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (ctrl_word !== e) begin
                    fails++;
                    $display("FAIL %s: ctrl_word actual %h expected %h", t, ctrl_word, e);
                end
                if (ctrl_word[31:28] !== 4'h0) begin
                    checks++;
                    fails++;
                    $display("FAIL R11: reserved bits actual %h expected 0", ctrl_word[31:28]);
                end
            end
        end
    end

    initial begin
        #(PERIOD * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        opcode   = 8'h00;
        acc_sign = 1'b0;
        repeat (2) @(negedge clk);
        push(32'h0, "R1 reset");
        drain();
        @(negedge clk);
        rst_n = 1'b1;

        two_op(8'h02, 'h19, 3, 1'b1, "R5 LOAD");
        two_op(8'h03, 'h1E, 3, 1'b0, "R5 ADD");
        two_op(8'h04, 'h23, 4, 1'b0, "R5 SUB");
        two_op(8'h06, 'h28, 6, 1'b0, "R5 AND");
        two_op(8'h07, 'h2D, 7, 1'b0, "R5 OR");
        two_op(8'h0B, 'h46, 11, 1'b0, "R5 MPY");

        fetch(8'h01, 'h14);
        push(MARM | INC, "R6");
        push(MBRA | PCINC | WR | INC, "R6");
        push(BACK, "R6");
        drain();

        one_op(8'h08, 'h32, 8);
        one_op(8'h09, 'h37, 9);
        one_op(8'h0A, 'h3C, 10);

        jump(1'b0);
        jump(1'b1);
        acc_sign = 1'b0;

        // R10: undefined opcode lands on a filler word
        fetch(8'h0D, 'h00);
        void'(exp_q.pop_back());
        void'(tag_q.pop_back());
        push(BACK, "R10 filler");
        drain();

        // R9: halt spins until reset
        fetch(8'h0C, 'h4B);
        for (int i = 0; i < 5; i++) push(JMP | 32'h4B, "R9 halt");
        drain();
        @(negedge clk);
        rst_n = 1'b0;
        push(32'h0, "R1 reset in halt");
        push(32'h0, "R1 reset in halt");
        drain();
        @(negedge clk);
        rst_n = 1'b1;
        two_op(8'h03, 'h1E, 3, 1'b0, "R1 restart");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule